// File: doc/BRIEF.md
# GPIO Data and Direction Register Block

This block is the data path of a 16-pin general-purpose I/O bank behind a small 32-bit register bus. Every pin has its own direction bit and its own output data bit. The pad output enable and the pad output value come straight from those two registers. Software can turn single output bits on or off without a read-modify-write sequence. It does this through two alias addresses, one that sets bits and one that clears them. Both aliases read back the stored output data.

The pad inputs pass through a two-stage synchronizer on the block clock. The synchronized level is presented at a read-only input address. That address always reports the real pin level, whatever the direction and output settings are, so software can read back a pin that it is driving itself.

The register bus is minimal. A write is taken on the clock edge while the write enable is high. Read data is a combinational function of the address.

Top module: `gpio_dd_top`

## Requirements
- R1: After a synchronous reset, the direction register reads 0x0000FFFF (all pins inputs), the output data register reads 0, and pad_oe and pad_out are all 0.
- R2: Byte offset 0x10 holds the direction register, read/write. A bit value of 1 selects input and 0 selects output. pad_oe[n] equals the inverse of direction bit n from the clock edge after the write.
- R3: Byte offset 0x14 holds the output data register. A write stores the value and a read returns the stored value, not the pin level. pad_out[n] equals output bit n. On a pin set as input, pad_oe stays 0, so the output bit cannot reach the pin. Changing a bit by read-modify-write at 0x14 gives the same register contents as changing it through the alias addresses.
- R4: Byte offset 0x18 is the set alias. Writing 1 in bit n sets output bit n. Writing 0 leaves the bit unchanged. A read returns the output data register.
- R5: Byte offset 0x1C is the clear alias. Writing 1 in bit n clears output bit n. Writing 0 leaves the bit unchanged. A read returns the output data register.
- R6: Byte offset 0x20 reads the pad_in levels after a two-stage synchronizer. A change in pad_in that is set up before clock edge k is not visible after edge k, and is visible after edge k+1. The value does not depend on direction or output data. Writes to this offset change nothing.
- R7: Bits 31:16 of every register read as 0, and write data in those bits is ignored.
- R8: Reads from any offset other than the five above return 0. Writes to any such offset leave the direction and output registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Output value to the pads |
| pad_oe | output | 16 | Output enable to the pads, 1 drives the pin |

## Verification
The bench builds the block with its default of 16 pins, so every pin and the full 16-bit register space can be swept exhaustively. Walking-one and walking-zero patterns, plus a long pseudo-random sequence of mixed set, clear and direct writes, are applied against an arithmetic model of the two registers. A byte-address sweep reaches every unmapped offset in the 8-bit address space. The narrow pin count also leaves a full upper half-word of each register to prove that those bits read as zero.

// File: rtl/gpio_dd_pkg.sv
package gpio_dd_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned ADR_W = 8;

    localparam logic [ADR_W-1:0] ADR_DIR = 8'h10;
    localparam logic [ADR_W-1:0] ADR_OUT = 8'h14;
    localparam logic [ADR_W-1:0] ADR_SET = 8'h18;
    localparam logic [ADR_W-1:0] ADR_CLR = 8'h1C;
    localparam logic [ADR_W-1:0] ADR_PIN = 8'h20;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_DIR,
        RD_OUT,
        RD_PIN
    } rd_src_e;

    typedef struct packed {
        logic    wr_dir;
        logic    wr_out;
        logic    wr_set;
        logic    wr_clr;
        rd_src_e src;
    } acc_t;

    function automatic acc_t decode(input logic [ADR_W-1:0] a, input logic we);
        acc_t r;
        r = '{wr_dir: 1'b0, wr_out: 1'b0, wr_set: 1'b0, wr_clr: 1'b0, src: RD_ZERO};
        case (a)
            ADR_DIR: begin r.wr_dir = we; r.src = RD_DIR; end
            ADR_OUT: begin r.wr_out = we; r.src = RD_OUT; end
            ADR_SET: begin r.wr_set = we; r.src = RD_OUT; end
            ADR_CLR: begin r.wr_clr = we; r.src = RD_OUT; end
            ADR_PIN: r.src = RD_PIN;
            default: r.src = RD_ZERO;
        endcase
        return r;
    endfunction

    // Next output data: direct write wins, otherwise clear then set (set has priority).
    function automatic logic [BUS_W-1:0] merge_out(input logic [BUS_W-1:0] cur,
                                                   input logic [BUS_W-1:0] wd,
                                                   input acc_t acc);
        logic [BUS_W-1:0] setm;
        logic [BUS_W-1:0] clrm;
        setm = acc.wr_set ? wd : '0;
        clrm = acc.wr_clr ? wd : '0;
        if (acc.wr_out) return wd;
        return (cur & ~clrm) | setm;
    endfunction

endpackage

// File: rtl/gpio_dd_sync.sv
module gpio_dd_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_dd_ctrl.sv
module gpio_dd_ctrl
    import gpio_dd_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  acc_t                 acc,
    input  logic [BUS_W-1:0]     wdata,
    output logic [PIN_COUNT-1:0] dir_q,
    output logic [PIN_COUNT-1:0] out_q
);
    logic [BUS_W-1:0] cur_ext;
    logic [BUS_W-1:0] nxt_ext;

    always_comb begin
        cur_ext = '0;
        cur_ext[PIN_COUNT-1:0] = out_q;
        nxt_ext = merge_out(cur_ext, wdata, acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            out_q <= '0;
        end else begin
            if (acc.wr_dir) dir_q <= wdata[PIN_COUNT-1:0];
            out_q <= nxt_ext[PIN_COUNT-1:0];
        end
    end
endmodule

// File: rtl/gpio_dd_rdmux.sv
module gpio_dd_rdmux
    import gpio_dd_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 16
) (
    input  rd_src_e              src,
    input  logic [PIN_COUNT-1:0] dir_q,
    input  logic [PIN_COUNT-1:0] out_q,
    input  logic [PIN_COUNT-1:0] pin_q,
    output logic [BUS_W-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        case (src)
            RD_DIR:  rdata[PIN_COUNT-1:0] = dir_q;
            RD_OUT:  rdata[PIN_COUNT-1:0] = out_q;
            RD_PIN:  rdata[PIN_COUNT-1:0] = pin_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_dd_top.sv
module gpio_dd_top
    import gpio_dd_pkg::*;
#(
    parameter int unsigned PIN_COUNT   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADR_W-1:0]     bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    acc_t                 acc;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] out_q;
    logic [PIN_COUNT-1:0] pin_q;

    assign acc = decode(bus_addr, bus_we);

    gpio_dd_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_q)
    );

    gpio_dd_ctrl #(.PIN_COUNT(PIN_COUNT)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_dd_rdmux #(.PIN_COUNT(PIN_COUNT)) u_rdmux (
        .src   (acc.src),
        .dir_q (dir_q),
        .out_q (out_q),
        .pin_q (pin_q),
        .rdata (bus_rdata)
    );

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_dd_chk.sv
module gpio_dd_chk
    import gpio_dd_pkg::*;
#(
    parameter int unsigned PIN_COUNT   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADR_W-1:0]     bus_addr,
    input logic                 bus_we,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [PIN_COUNT-1:0] pad_in,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_oe
);
    logic [1:0] since_rst;
    logic       out_wr;
    logic       mapped;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign out_wr = bus_we && (bus_addr == ADR_OUT || bus_addr == ADR_SET || bus_addr == ADR_CLR);
    assign mapped = (bus_addr == ADR_DIR || bus_addr == ADR_OUT || bus_addr == ADR_SET ||
                     bus_addr == ADR_CLR || bus_addr == ADR_PIN);

    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_out == '0));

    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_DIR) |=> pad_oe == ~$past(bus_wdata[PIN_COUNT-1:0]));

    a_r3_out_holds: assert property (@(posedge clk) disable iff (rst)
        !out_wr |=> $stable(pad_out));

    a_r4_set_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_SET) |=>
            ((pad_out & $past(bus_wdata[PIN_COUNT-1:0])) == $past(bus_wdata[PIN_COUNT-1:0])));

    a_r5_clr_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_CLR) |=> ((pad_out & $past(bus_wdata[PIN_COUNT-1:0])) == '0));

    a_r6_pin_latency: assert property (@(posedge clk) disable iff (rst)
        (SYNC_STAGES == 2 && since_rst >= 2'd2 && bus_addr == ADR_PIN) |->
            bus_rdata[PIN_COUNT-1:0] == $past(pad_in, 2));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:16] == '0);

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == '0);
endmodule

bind gpio_dd_top gpio_dd_chk #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/gpio_dd_top_bench.sv
module gpio_dd_top_bench;
    import gpio_dd_pkg::*;

    localparam int PINS = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       bus_addr = '0;
    logic             bus_we = 1'b0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [PINS-1:0]  pad_in = '0;
    logic [PINS-1:0]  pad_out;
    logic [PINS-1:0]  pad_oe;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_dir;
    logic [31:0] exp_out;

    always #5 clk = ~clk;

    gpio_dd_top u_gpio_dd_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic chk_state(input string tag);
        logic [31:0] v;
        rd(ADR_DIR, v); chk({tag, " R2 dir readback"}, v, exp_dir);
        rd(ADR_OUT, v); chk({tag, " R3 out readback"}, v, exp_out);
        chk({tag, " R2 pad_oe"}, {16'h0, pad_oe}, {16'h0, ~exp_dir[15:0]});
        chk({tag, " R3 pad_out"}, {16'h0, pad_out}, {16'h0, exp_out[15:0]});
    endtask

    function automatic logic [15:0] lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic pin_step(input logic [15:0] p);
        logic [15:0] old;
        old = pad_in;
        @(negedge clk);
        pad_in = p; bus_addr = ADR_PIN; bus_we = 1'b0;
        @(negedge clk); #1 chk("R6 one edge shows old level", bus_rdata, {16'h0, old});
        @(negedge clk); #1 chk("R6 two edges show new level", bus_rdata, {16'h0, p});
    endtask

    initial begin : watchdog
        #2_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] a_val;
        logic [31:0] b_val;
        logic [15:0] s;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(ADR_DIR, v); chk("R1 dir after reset", v, 32'h0000FFFF);
        rd(ADR_OUT, v); chk("R1 out after reset", v, 32'h0);
        chk("R1 pad_oe after reset", {16'h0, pad_oe}, 32'h0);
        chk("R1 pad_out after reset", {16'h0, pad_out}, 32'h0);
        exp_dir = 32'h0000FFFF; exp_out = '0;

        // R2 walking-one / walking-zero direction, upper bits ignored (R7)
        for (int i = 0; i < PINS; i++) begin
            wr(ADR_DIR, 32'hA5A50000 | (32'h1 << i)); exp_dir = 32'h1 << i; chk_state("walk1 dir");
            wr(ADR_DIR, 32'hFFFF0000 | (~(32'h1 << i) & 32'hFFFF)); exp_dir = ~(32'h1 << i) & 32'hFFFF;
            chk_state("walk0 dir");
        end

        // R3 direct output writes, with all pins inputs (pad_oe stays low) and all outputs
        wr(ADR_DIR, 32'hFFFF); exp_dir = 32'hFFFF;
        wr(ADR_OUT, 32'h5A5A_C3C3); exp_out = 32'hC3C3; chk_state("R3 inputs out ignored");
        wr(ADR_DIR, 32'h0); exp_dir = 32'h0;
        wr(ADR_OUT, 32'h1234); exp_out = 32'h1234; chk_state("R3 outputs drive");

        // R4 / R5 per-bit set and clear with alias readback
        wr(ADR_OUT, 32'h0); exp_out = 32'h0;
        for (int i = 0; i < PINS; i++) begin
            wr(ADR_SET, 32'h1 << i); exp_out |= 32'h1 << i;
            rd(ADR_SET, v); chk("R4 set alias readback", v, exp_out);
            chk("R4 set pad_out", {16'h0, pad_out}, exp_out);
        end
        for (int i = 0; i < PINS; i++) begin
            wr(ADR_CLR, 32'hFFFF0000 | (32'h1 << i)); exp_out &= ~(32'h1 << i);
            rd(ADR_CLR, v); chk("R5 clr alias readback", v, exp_out);
            chk("R5 clr pad_out", {16'h0, pad_out}, exp_out);
        end
        wr(ADR_SET, 32'h0); wr(ADR_CLR, 32'h0); chk_state("R4 R5 zero writes no effect");

        // mixed pseudo-random set/clear/direct/dir writes
        s = 16'hACE1;
        for (int k = 0; k < 200; k++) begin
            s = lfsr(s);
            case (k % 4)
                0: begin wr(ADR_SET, {16'hFFFF, s}); exp_out |= {16'h0, s}; end
                1: begin wr(ADR_CLR, {16'hFFFF, s}); exp_out &= ~{16'h0, s}; end
                2: begin wr(ADR_OUT, {s, s}); exp_out = {16'h0, s}; end
                default: begin wr(ADR_DIR, {s, ~s}); exp_dir = {16'h0, ~s}; end
            endcase
            chk_state("random R3 R4 R5 R7");
        end

        // R3 read-modify-write equals alias result
        for (int i = 0; i < PINS; i++) begin
            wr(ADR_OUT, 32'h0F0F); rd(ADR_OUT, v);
            wr(ADR_OUT, v ^ (32'h1 << i)); rd(ADR_OUT, a_val);
            wr(ADR_OUT, 32'h0F0F);
            if (v[i]) wr(ADR_CLR, 32'h1 << i); else wr(ADR_SET, 32'h1 << i);
            rd(ADR_OUT, b_val);
            chk("R3 rmw matches alias", a_val, b_val);
            chk("R3 rmw value", a_val, 32'h0F0F ^ (32'h1 << i));
        end
        exp_out = 32'h0F0F ^ (32'h1 << (PINS-1));

        // R6 input synchronizer under different directions and writes to input offset
        wr(ADR_DIR, 32'h0); exp_dir = 32'h0;
        pin_step(16'hFFFF); pin_step(16'h0000);
        for (int i = 0; i < PINS; i++) pin_step(16'h1 << i);
        wr(ADR_DIR, 32'hFFFF); exp_dir = 32'hFFFF;
        pin_step(16'hBEEF); pin_step(16'h4110);
        wr(ADR_PIN, 32'hFFFF_FFFF);
        rd(ADR_PIN, v); chk("R6 write to input ignored", v, 32'h4110);
        chk_state("R6 write to input leaves regs");

        // R8 unmapped offsets
        for (int a = 0; a < 256; a++) begin
            if (a == 'h10 || a == 'h14 || a == 'h18 || a == 'h1C || a == 'h20) continue;
            rd(8'(a), v); chk("R8 unmapped read zero", v, 32'h0);
            if (a % 16 == 1) begin
                wr(8'(a), 32'hFFFF_FFFF); wr(8'(a), 32'h0);
                chk_state("R8 unmapped write no effect");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule